// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block produces the timing of one analog multiplexer frame. A slow sample clock (32768 Hz) reaches it as a one-cycle enable, `tick`, on the fast system clock. Every frame is thirteen ticks long. The first tick is a settling cycle. The remaining twelve ticks are split into conversion slots of equal length. For each slot the block presents the channel code that the slot selects. On the last tick of each slot it issues a write strobe. The strobe carries the sampled ADC result and a word address tied directly to the channel code.

Software-facing configuration is plain inputs:
- the conversions per frame;
- a one-bit conversion-length select;
- two packed per-slot channel tables, one primary and one alternate.

The configuration is sampled only at frame boundaries. An inconsistent setting raises an error flag, and the frame then runs with the default arrangement of six slots of two ticks. A frame-done strobe and a data-valid flag mark the moment the raw results of a frame are complete.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, `busy`, `wr_en`, `frame_done`, `data_valid` and `cfg_err` are 0. The first frame uses 6 slots of 2 ticks, and the frame parity is even.
- R2: The frame position advances only on cycles with `tick`=1. A frame spans 13 ticks, and the first of them is a settling tick with `busy`=0 and no write. `wr_en` is never 1 while `tick`=0.
- R3: `cfg_flen`=0 gives 2 ticks per slot and `cfg_flen`=1 gives 3 ticks per slot. `wr_en` pulses on the last tick of each slot, so a frame has exactly as many writes as it has slots.
- R4: During slot k, `chan` is the 3-bit field k of the active table, at bits [3k+2:3k]. Channel codes are 0=IA, 1=VA, 2=IB, 3=VB, 4=IC, 5=VC, 6=ID. `wr_addr` equals that code.
- R5: When `alt_en`=1 and the frame parity is odd, `sel_alt` is used in place of `sel_pri`. The parity flips at every frame end.
- R6: `cfg_nconv` and `cfg_flen` are sampled on the final tick of a frame and apply to the next frame. If `cfg_nconv` times the slot length is not 12, `cfg_err` is 1 for that frame and the frame runs as 6 slots of 2 ticks.
- R7: `frame_done` is 1 for exactly the one clock that follows the 13th tick of a frame. `data_valid` goes to 1 on that same edge.
- R8: `data_valid` returns to 0 after the first result write of the following frame.
- R9: While `wr_en`=1, `wr_data` equals `adc_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the sample rate |
| cfg_nconv | input | 3 | Requested conversions per frame |
| cfg_flen | input | 1 | Slot length select (0: 2 ticks, 1: 3 ticks) |
| alt_en | input | 1 | Enables the alternate table on odd frames |
| sel_pri | input | 18 | Primary channel code per slot, 3 bits each |
| sel_alt | input | 18 | Alternate channel code per slot, 3 bits each |
| adc_data | input | 22 | Converter result for the current slot |
| busy | output | 1 | Frame is past its settling tick |
| slot_idx | output | 3 | Current slot number |
| chan | output | 3 | Channel code of the current slot |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 3 | Raw-data word address |
| wr_data | output | 22 | Result to store |
| frame_done | output | 1 | One-clock end-of-frame strobe |
| data_valid | output | 1 | Raw results of the last frame are complete |
| cfg_err | output | 1 | Active frame runs on default settings |

## Verification
The assertions assume that `tick` never occurs on two adjacent frame ends. This always holds, because a frame needs 13 ticks. They also assume that configuration inputs matter only at the final tick of a frame. The stimulus changes the configuration inputs and tables only between ticks. It spaces ticks by random gaps of zero to three idle clocks. It draws channel codes only from 0 to 6. It mixes the two legal configurations with random illegal counts, so that the default fallback is exercised.

// File: rtl/adc_frame_seq_pkg.sv
package adc_frame_seq_pkg;
  localparam int FRAME_CYC = 13;
  localparam int MAX_SLOTS = 6;
  localparam int N_CH      = 7;
  localparam int CH_W      = 3;
  localparam int NCONV_W   = 3;
  localparam int LEN_W     = 2;
  localparam int LEN_SHORT = 2;
  localparam int LEN_LONG  = 3;
  localparam int DEF_NCONV = 6;
  localparam int CYC_W     = $clog2(FRAME_CYC);
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
endpackage

// File: rtl/adc_frame_cfg_check.sv
module adc_frame_cfg_check
  import adc_frame_seq_pkg::*;
(
  input  logic [NCONV_W-1:0] nconv,
  input  logic               flen,
  output logic               ok,
  output logic [LEN_W-1:0]   len
);
  localparam int PROD_W = NCONV_W + LEN_W;
  logic [PROD_W-1:0] prod;

  always_comb begin
    len  = flen ? LEN_W'(LEN_LONG) : LEN_W'(LEN_SHORT);
    prod = PROD_W'(nconv) * PROD_W'(len);
    ok   = (prod == PROD_W'(FRAME_CYC - 1));
  end
endmodule

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
  import adc_frame_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  len,
  output logic [CYC_W-1:0]  cyc,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_end,
  output logic              frame_end
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(FRAME_CYC - 1);

  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [LEN_W-1:0]  phase_q, phase_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              ph_last;

  assign ph_last   = (phase_q == len - LEN_W'(1));
  assign slot_end  = tick && (cyc_q != '0) && ph_last;
  assign frame_end = tick && (cyc_q == LAST);
  assign cyc       = cyc_q;
  assign slot      = slot_q;

  always_comb begin
    cyc_d   = cyc_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    if (tick) begin
      if (cyc_q == LAST) begin
        cyc_d   = '0;
        phase_d = '0;
        slot_d  = '0;
      end else begin
        cyc_d = cyc_q + CYC_W'(1);
        if (cyc_q != '0) begin
          if (ph_last) begin
            phase_d = '0;
            slot_d  = slot_q + SLOT_W'(1);
          end else begin
            phase_d = phase_q + LEN_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      phase_q <= '0;
      slot_q  <= '0;
    end else if (tick) begin
      cyc_q   <= cyc_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
    end
  end

  // R2
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cyc_q));
  // R2
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LAST);
  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < len);
endmodule

// File: rtl/adc_frame_slot_mux.sv
module adc_frame_slot_mux
  import adc_frame_seq_pkg::*;
(
  input  logic [MAX_SLOTS*CH_W-1:0] sel_pri,
  input  logic [MAX_SLOTS*CH_W-1:0] sel_alt,
  input  logic [SLOT_W-1:0]         slot,
  input  logic                      use_alt,
  output logic [CH_W-1:0]           chan
);
  logic [CH_W-1:0] pri_tab [MAX_SLOTS];
  logic [CH_W-1:0] alt_tab [MAX_SLOTS];

  for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_unpack
    assign pri_tab[k] = sel_pri[k*CH_W +: CH_W];
    assign alt_tab[k] = sel_alt[k*CH_W +: CH_W];
  end

  always_comb begin
    chan = '0;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      if (slot == SLOT_W'(k)) chan = use_alt ? alt_tab[k] : pri_tab[k];
    end
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_frame_seq_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [NCONV_W-1:0]        cfg_nconv,
  input  logic                      cfg_flen,
  input  logic                      alt_en,
  input  logic [MAX_SLOTS*CH_W-1:0] sel_pri,
  input  logic [MAX_SLOTS*CH_W-1:0] sel_alt,
  input  logic [DATA_W-1:0]         adc_data,
  output logic                      busy,
  output logic [SLOT_W-1:0]         slot_idx,
  output logic [CH_W-1:0]           chan,
  output logic                      wr_en,
  output logic [CH_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      frame_done,
  output logic                      data_valid,
  output logic                      cfg_err
);
  logic [NCONV_W-1:0] nconv_q, nconv_d;
  logic [LEN_W-1:0]   len_q, len_d, chk_len;
  logic               err_q, err_d, chk_ok;
  logic               par_q, par_d;
  logic               done_q, done_d;
  logic               valid_q, valid_d;
  logic [CYC_W-1:0]   cyc;
  logic               slot_end, frame_end;

  adc_frame_cfg_check u_chk (
    .nconv (cfg_nconv),
    .flen  (cfg_flen),
    .ok    (chk_ok),
    .len   (chk_len)
  );

  adc_frame_timer u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .len       (len_q),
    .cyc       (cyc),
    .slot      (slot_idx),
    .slot_end  (slot_end),
    .frame_end (frame_end)
  );

  adc_frame_slot_mux u_mux (
    .sel_pri (sel_pri),
    .sel_alt (sel_alt),
    .slot    (slot_idx),
    .use_alt (alt_en && par_q),
    .chan    (chan)
  );

  always_comb begin
    nconv_d = nconv_q;
    len_d   = len_q;
    err_d   = err_q;
    par_d   = par_q;
    valid_d = valid_q;
    done_d  = frame_end;
    if (slot_end) valid_d = 1'b0;
    if (frame_end) begin
      par_d   = ~par_q;
      valid_d = 1'b1;
      err_d   = ~chk_ok;
      nconv_d = chk_ok ? cfg_nconv : NCONV_W'(DEF_NCONV);
      len_d   = chk_ok ? chk_len   : LEN_W'(LEN_SHORT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nconv_q <= NCONV_W'(DEF_NCONV);
      len_q   <= LEN_W'(LEN_SHORT);
      err_q   <= 1'b0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      nconv_q <= nconv_d;
      len_q   <= len_d;
      err_q   <= err_d;
      par_q   <= par_d;
      done_q  <= done_d;
      valid_q <= valid_d;
    end
  end

  assign busy       = (cyc != '0);
  assign wr_en      = slot_end;
  assign wr_addr    = chan;
  assign wr_data    = adc_data;
  assign frame_done = done_q;
  assign data_valid = valid_q;
  assign cfg_err    = err_q;

  // R2
  settle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !tick) |-> !wr_en);
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot_idx < SLOT_W'(nconv_q)));
  // R6
  err_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (nconv_q == NCONV_W'(DEF_NCONV) && len_q == LEN_W'(LEN_SHORT)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R7
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> data_valid);
  // R8
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !frame_end) |=> !data_valid);
endmodule

// File: tb/sim_adc_frame_seq.sv
`timescale 1ns/1ps
module sim_adc_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  cfg_nconv = 3'd6;
  logic        cfg_flen = 1'b0;
  logic        alt_en = 1'b0;
  logic [17:0] sel_pri = '0;
  logic [17:0] sel_alt = '0;
  logic [21:0] adc_data = '0;
  logic        busy, wr_en, frame_done, data_valid, cfg_err;
  logic [2:0]  slot_idx, chan, wr_addr;
  logic [21:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  int b_cyc = 0, b_nconv = 6, b_len = 2;
  bit b_par = 0, b_valid = 0, b_err = 0;
  int writes_in_frame = 0;

  always #2.5 clk = ~clk;

  adc_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_nconv(cfg_nconv),
    .cfg_flen(cfg_flen), .alt_en(alt_en), .sel_pri(sel_pri), .sel_alt(sel_alt),
    .adc_data(adc_data), .busy(busy), .slot_idx(slot_idx), .chan(chan),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .data_valid(data_valid), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_chan(input int slot);
    logic [17:0] t;
    t = (alt_en && b_par) ? sel_alt : sel_pri;
    return int'(t[slot*3 +: 3]);
  endfunction

  function automatic logic [17:0] rand_tab();
    logic [17:0] t;
    for (int k = 0; k < 6; k++) t[k*3 +: 3] = 3'($urandom_range(6, 0));
    return t;
  endfunction

  task automatic do_tick(input int gap);
    bit exp_wr, fin;
    int slot, c;
    @(negedge clk);
    tick = 1'b1;
    adc_data = 22'($urandom);
    #1;
    exp_wr = (b_cyc != 0) && (((b_cyc - 1) % b_len) == b_len - 1);
    slot = (b_cyc == 0) ? 0 : (b_cyc - 1) / b_len;
    chk(busy == (b_cyc != 0), "R2 busy", busy, b_cyc != 0);
    chk(wr_en == exp_wr, "R3 wr_en", wr_en, exp_wr);
    if (b_cyc != 0) begin
      c = exp_chan(slot);
      chk(int'(chan) == c, (alt_en && b_par) ? "R5 alt chan" : "R4 chan", chan, c);
    end
    if (exp_wr) begin
      chk(int'(wr_addr) == c, "R4 wr_addr", wr_addr, c);
      chk(wr_data == adc_data, "R9 wr_data", wr_data, adc_data);
      writes_in_frame++;
    end
    fin = (b_cyc == 12);
    @(posedge clk);
    #1;
    tick = 1'b0;
    if (exp_wr) b_valid = 0;
    if (fin) begin
      chk(writes_in_frame == b_nconv, "R3 writes per frame", writes_in_frame, b_nconv);
      writes_in_frame = 0;
      b_valid = 1;
      b_par = ~b_par;
      if (int'(cfg_nconv) * (cfg_flen ? 3 : 2) == 12) begin
        b_err = 0; b_nconv = cfg_nconv; b_len = cfg_flen ? 3 : 2;
      end else begin
        b_err = 1; b_nconv = 6; b_len = 2;
      end
      b_cyc = 0;
    end else begin
      b_cyc++;
    end
    chk(frame_done == fin, "R7 frame_done", frame_done, fin);
    chk(data_valid == b_valid, "R8 data_valid", data_valid, b_valid);
    chk(cfg_err == b_err, "R6 cfg_err", cfg_err, b_err);
    for (int g = 0; g < gap; g++) begin
      @(posedge clk);
      #1;
      chk(wr_en == 1'b0, "R2 idle wr_en", wr_en, 0);
      chk(frame_done == 1'b0, "R7 pulse width", frame_done, 0);
      chk(busy == (b_cyc != 0), "R2 hold", busy, b_cyc != 0);
    end
  endtask

  task automatic run_frames(input int n, input int maxgap);
    for (int f = 0; f < n * 13; f++) do_tick($urandom_range(maxgap, 0));
  endtask

  initial begin
    void'($urandom(32'd4242));
    sel_pri = {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};
    sel_alt = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wr_en == 0, "R1 wr_en", wr_en, 0);
    chk(frame_done == 0, "R1 frame_done", frame_done, 0);
    chk(data_valid == 0, "R1 data_valid", data_valid, 0);
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    // R1 R3 R4: default frame, ticks on every clock
    cfg_nconv = 3'd2; // illegal but sampled only at frame end (R6)
    do_tick(0);
    cfg_nconv = 3'd6;
    run_frames(2, 0);
    // R3 R5: 4 slots of 3 ticks with alternate table
    cfg_nconv = 3'd4; cfg_flen = 1'b1; alt_en = 1'b1;
    run_frames(3, 2);
    // R6: illegal count falls back to defaults
    cfg_nconv = 3'd5; cfg_flen = 1'b0;
    run_frames(2, 1);
    // R6: legal count with wrong length select
    cfg_nconv = 3'd6; cfg_flen = 1'b1;
    run_frames(1, 0);
    // Random configurations, tables and gaps
    for (int r = 0; r < 12; r++) begin
      case ($urandom_range(3, 0))
        0: begin cfg_nconv = 3'd6; cfg_flen = 1'b0; end
        1: begin cfg_nconv = 3'd4; cfg_flen = 1'b1; end
        default: begin cfg_nconv = 3'($urandom); cfg_flen = 1'($urandom); end
      endcase
      alt_en = 1'($urandom);
      sel_pri = rand_tab();
      sel_alt = rand_tab();
      run_frames(1, 3);
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule